// File: doc/BRIEF.md
# Power Mode Sequencer with Wake Logic

This block controls the operating mode of a small microcontroller core. There are four modes: a full-speed run mode on the fast oscillator, a low-speed run mode on the slow oscillator, an idle mode, and a stop mode. In idle the CPU and the fast oscillator are halted while the slow oscillator keeps running. In stop every clock is off. Software selects a mode by writing a two-bit code on a request strobe. The block drives the oscillator gates, the select lines of the CPU clock mux, a divided CPU clock strobe and the watchdog enable to match the current mode.

While the core is in idle or stop, the block watches the wake sources. These are three external interrupt pins, each with a software-chosen edge polarity, and an active-low 8-bit port. In idle only, two more sources count: a timebase-timer interrupt and a PWM interrupt, and each counts only when that peripheral runs from the slow clock. A valid wake event returns the core to the run mode it left and gives the CPU a one-cycle wake pulse. The external pins go through a two-flop synchronizer. In stop, a raw-pin comparison wakes the core without waiting for the synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the mode is fast run (mode code 0). Both oscillator gates are on, the fast CPU select is on, the slow CPU select is off, the watchdog enable is high and the wake pulse is low.
- R2: Mode codes are 0 fast run, 1 slow run, 2 idle and 3 stop. Each mode sets the outputs (fast osc, slow osc, fast sel, slow sel) as follows: fast run gives 1,1,1,0. Slow run gives 0,1,0,1. Idle gives 0,1,0,0. Stop gives 0,0,0,0.
- R3: The two CPU clock selects are never high together. A switch between fast run and slow run holds both selects low for exactly GAP_CYCLES cycles (default 2) before the new select rises, with both oscillators on during the gap.
- R4: The watchdog enable is low in idle and stop and high in every other state.
- R5: Each external pin's polarity bit selects the edge: 1 means rising, 0 means falling. The selected edge produces one high cycle on that pin's ext_irq_o bit, two cycles after the pin changes. The opposite edge produces nothing.
- R6: A selected edge on any external pin wakes the core from idle or stop. An opposite edge leaves it in the low-power mode.
- R7: A low level on any bit of port B wakes the core from idle (after the 2-flop synchronizer, 3 cycles) and from stop (1 cycle).
- R8: In idle, the timebase interrupt wakes the core only when its slow-source flag is 1. The same rule applies to the PWM interrupt and its own flag. Either wake takes effect at the next clock edge.
- R9: In stop, the timebase and PWM interrupts are ignored whatever their source flags.
- R10: A wake returns the core to the run mode that was active before the low-power entry. wake_o is high for exactly one cycle, the first cycle back in that run mode.
- R11: In stop, an external edge wakes the core at the first clock edge after the pin changes, before the synchronized interrupt pulse appears.
- R12: While the CPU runs, cpu_tick_o strobes once every 1, 2, 4 or 8 cycles for div_sel_i values 0, 1, 2 and 3. In idle and stop it stays low.
- R13: Mode requests made in idle, in stop or during a clock switch are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode code |
| div_sel_i | input | 2 | CPU clock divide select (1/2/4/8) |
| ext_pin_i | input | 3 | External interrupt pins |
| ext_rise_i | input | 3 | Per-pin polarity, 1 = rising |
| port_b_i | input | 8 | Port B levels, low wakes |
| tbt_irq_i | input | 1 | Timebase-timer interrupt |
| tbt_slow_src_i | input | 1 | Timebase timer runs from slow clock |
| pwm_irq_i | input | 1 | PWM0 interrupt |
| pwm_slow_src_i | input | 1 | PWM0 runs from slow clock |
| mode_o | output | 2 | Current mode code (target during a switch) |
| fast_osc_en_o | output | 1 | Fast oscillator gate |
| slow_osc_en_o | output | 1 | Slow oscillator gate |
| cpu_fast_sel_o | output | 1 | CPU clock mux selects fast clock |
| cpu_slow_sel_o | output | 1 | CPU clock mux selects slow clock |
| cpu_tick_o | output | 1 | Divided CPU clock strobe |
| wdt_en_o | output | 1 | Watchdog enable |
| wake_o | output | 1 | One-cycle wake pulse to CPU |
| ext_irq_o | output | 3 | Synchronized edge interrupt per pin |

## Verification
The hardest case to reach is the stop-mode raw wake path. To tell it apart from the synchronized path, the bench has to see the core back in run mode while the synchronized interrupt bit is still low. That window lasts one cycle. The bench therefore settles each pin at its starting level during a run mode, waits past the synchronizer depth, enters stop, and only then drives the edge, sampling on the very next cycle. It uses the same pre-settling to show that opposite edges are inert in both low-power modes, sweeping every pin, both polarities and both modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_FAST = 2'd0,
    MODE_SLOW = 2'd1,
    MODE_IDLE = 2'd2,
    MODE_STOP = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_FAST,
    ST_SLOW,
    ST_SWITCH,
    ST_IDLE,
    ST_STOP
  } state_e;
endpackage

// File: rtl/pmc_ext_sync.sv
module pmc_ext_sync #(
  parameter int N_EXT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] rise_i,
  output logic [N_EXT-1:0] edge_o,
  output logic [N_EXT-1:0] raw_edge_o
);
  logic [N_EXT-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    assign edge_o[g]     = rise_i[g] ? (s2_q[g] & ~s3_q[g]) : (~s2_q[g] & s3_q[g]);
    // raw pin against last synchronized level: usable while clocks are stopped
    assign raw_edge_o[g] = rise_i[g] ? (pin_i[g] & ~s2_q[g]) : (~pin_i[g] & s2_q[g]);
  end
endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
  parameter int N_EXT = 3,
  parameter int PB_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_idle_i,
  input  logic             in_stop_i,
  input  logic [N_EXT-1:0] ext_edge_i,
  input  logic [N_EXT-1:0] ext_raw_edge_i,
  input  logic [PB_W-1:0]  port_b_i,
  input  logic             tbt_irq_i,
  input  logic             tbt_slow_i,
  input  logic             pwm_irq_i,
  input  logic             pwm_slow_i,
  output logic             wake_o
);
  logic [PB_W-1:0] pb_s1_q, pb_s2_q;
  logic pb_low_sync, pb_low_raw, idle_wake, stop_wake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_s1_q <= '1;
      pb_s2_q <= '1;
    end else begin
      pb_s1_q <= port_b_i;
      pb_s2_q <= pb_s1_q;
    end
  end

  assign pb_low_sync = ~&pb_s2_q;
  assign pb_low_raw  = ~&port_b_i;

  assign idle_wake = (|ext_edge_i) | pb_low_sync
                   | (tbt_irq_i & tbt_slow_i) | (pwm_irq_i & pwm_slow_i);
  // no clock runs in stop: timers cannot fire, only pin levels count
  assign stop_wake = (|ext_raw_edge_i) | pb_low_raw;

  assign wake_o = (in_idle_i & idle_wake) | (in_stop_i & stop_wake);
endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, mask;

  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = (b < int'(div_sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_EXT      = 3,
  parameter int PB_W       = 8,
  parameter int DIV_SEL_W  = 2,
  parameter int GAP_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_mode_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [N_EXT-1:0]     ext_pin_i,
  input  logic [N_EXT-1:0]     ext_rise_i,
  input  logic [PB_W-1:0]      port_b_i,
  input  logic                 tbt_irq_i,
  input  logic                 tbt_slow_src_i,
  input  logic                 pwm_irq_i,
  input  logic                 pwm_slow_src_i,
  output logic [1:0]           mode_o,
  output logic                 fast_osc_en_o,
  output logic                 slow_osc_en_o,
  output logic                 cpu_fast_sel_o,
  output logic                 cpu_slow_sel_o,
  output logic                 cpu_tick_o,
  output logic                 wdt_en_o,
  output logic                 wake_o,
  output logic [N_EXT-1:0]     ext_irq_o
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  state_e           state_q, state_d;
  logic             ret_slow_q, ret_slow_d;
  logic             tgt_slow_q, tgt_slow_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             wake_q, wake_d;
  logic [N_EXT-1:0] ext_edge, ext_raw_edge;
  logic             wake_req, in_idle, in_stop;
  mode_e            mode;

  pmc_ext_sync #(.N_EXT(N_EXT)) u_ext_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .rise_i     (ext_rise_i),
    .edge_o     (ext_edge),
    .raw_edge_o (ext_raw_edge)
  );

  assign in_idle = (state_q == ST_IDLE);
  assign in_stop = (state_q == ST_STOP);

  pmc_wake_qual #(.N_EXT(N_EXT), .PB_W(PB_W)) u_wake_qual (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .in_idle_i      (in_idle),
    .in_stop_i      (in_stop),
    .ext_edge_i     (ext_edge),
    .ext_raw_edge_i (ext_raw_edge),
    .port_b_i       (port_b_i),
    .tbt_irq_i      (tbt_irq_i),
    .tbt_slow_i     (tbt_slow_src_i),
    .pwm_irq_i      (pwm_irq_i),
    .pwm_slow_i     (pwm_slow_src_i),
    .wake_o         (wake_req)
  );

  always_comb begin
    state_d    = state_q;
    ret_slow_d = ret_slow_q;
    tgt_slow_d = tgt_slow_q;
    gap_d      = gap_q;
    wake_d     = 1'b0;
    unique case (state_q)
      ST_FAST, ST_SLOW: begin
        if (req_valid_i) begin
          unique case (mode_e'(req_mode_i))
            MODE_FAST: if (state_q == ST_SLOW) begin
              state_d    = ST_SWITCH;
              tgt_slow_d = 1'b0;
              gap_d      = '0;
            end
            MODE_SLOW: if (state_q == ST_FAST) begin
              state_d    = ST_SWITCH;
              tgt_slow_d = 1'b1;
              gap_d      = '0;
            end
            MODE_IDLE: begin
              state_d    = ST_IDLE;
              ret_slow_d = (state_q == ST_SLOW);
            end
            MODE_STOP: begin
              state_d    = ST_STOP;
              ret_slow_d = (state_q == ST_SLOW);
            end
            default: ;
          endcase
        end
      end
      ST_SWITCH: begin
        if (gap_q == GAP_LAST) state_d = tgt_slow_q ? ST_SLOW : ST_FAST;
        else                   gap_d   = gap_q + 1'b1;
      end
      ST_IDLE, ST_STOP: begin
        if (wake_req) begin
          state_d = ret_slow_q ? ST_SLOW : ST_FAST;
          wake_d  = 1'b1;
        end
      end
      default: state_d = ST_FAST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FAST;
      ret_slow_q <= 1'b0;
      tgt_slow_q <= 1'b0;
      gap_q      <= '0;
      wake_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      ret_slow_q <= ret_slow_d;
      tgt_slow_q <= tgt_slow_d;
      gap_q      <= gap_d;
      wake_q     <= wake_d;
    end
  end

  always_comb begin
    mode           = MODE_FAST;
    fast_osc_en_o  = 1'b0;
    slow_osc_en_o  = 1'b0;
    cpu_fast_sel_o = 1'b0;
    cpu_slow_sel_o = 1'b0;
    wdt_en_o       = 1'b1;
    unique case (state_q)
      ST_FAST: begin
        fast_osc_en_o  = 1'b1;
        slow_osc_en_o  = 1'b1;
        cpu_fast_sel_o = 1'b1;
      end
      ST_SLOW: begin
        mode           = MODE_SLOW;
        slow_osc_en_o  = 1'b1;
        cpu_slow_sel_o = 1'b1;
      end
      ST_SWITCH: begin
        mode          = tgt_slow_q ? MODE_SLOW : MODE_FAST;
        fast_osc_en_o = 1'b1;
        slow_osc_en_o = 1'b1;
      end
      ST_IDLE: begin
        mode          = MODE_IDLE;
        slow_osc_en_o = 1'b1;
        wdt_en_o      = 1'b0;
      end
      ST_STOP: begin
        mode     = MODE_STOP;
        wdt_en_o = 1'b0;
      end
      default: ;
    endcase
  end

  pmc_clk_div #(.SEL_W(DIV_SEL_W)) u_clk_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cpu_fast_sel_o | cpu_slow_sel_o),
    .div_sel_i (div_sel_i),
    .tick_o    (cpu_tick_o)
  );

  assign mode_o    = mode;
  assign wake_o    = wake_q;
  assign ext_irq_o = ext_edge;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       fast_osc_en_i,
  input logic       slow_osc_en_i,
  input logic       cpu_fast_sel_i,
  input logic       cpu_slow_sel_i,
  input logic       cpu_tick_i,
  input logic       wdt_en_i,
  input logic       wake_i
);
  a_r3_sel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_fast_sel_i && cpu_slow_sel_i));

  a_r3_slow_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_slow_sel_i) |-> !$past(cpu_fast_sel_i));

  a_r3_fast_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_fast_sel_i) |-> !$past(cpu_slow_sel_i));

  a_r4_wdt_low_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_en_i == !mode_i[1]);

  a_r2_stop_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> (!fast_osc_en_i && !slow_osc_en_i && !cpu_fast_sel_i && !cpu_slow_sel_i));

  a_r2_idle_slow_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> (slow_osc_en_i && !fast_osc_en_i && !cpu_fast_sel_i && !cpu_slow_sel_i));

  a_r10_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !wake_i);

  a_r10_wake_from_low_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_i) |-> ($past(mode_i[1]) && !mode_i[1]));

  a_r12_tick_needs_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_tick_i |-> (cpu_fast_sel_i || cpu_slow_sel_i));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_o),
  .fast_osc_en_i  (fast_osc_en_o),
  .slow_osc_en_i  (slow_osc_en_o),
  .cpu_fast_sel_i (cpu_fast_sel_o),
  .cpu_slow_sel_i (cpu_slow_sel_o),
  .cpu_tick_i     (cpu_tick_o),
  .wdt_en_i       (wdt_en_o),
  .wake_i         (wake_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int GAP        = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_mode_i = 2'd0;
  logic [1:0] div_sel_i = 2'd0;
  logic [2:0] ext_pin_i = 3'b000;
  logic [2:0] ext_rise_i = 3'b111;
  logic [7:0] port_b_i = 8'hFF;
  logic       tbt_irq_i = 1'b0, tbt_slow_src_i = 1'b0;
  logic       pwm_irq_i = 1'b0, pwm_slow_src_i = 1'b0;
  logic [1:0] mode_o;
  logic       fast_osc_en_o, slow_osc_en_o, cpu_fast_sel_o, cpu_slow_sel_o;
  logic       cpu_tick_o, wdt_en_o, wake_o;
  logic [2:0] ext_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwr_mode_ctrl #(.GAP_CYCLES(GAP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_mode_i(req_mode_i),
    .div_sel_i(div_sel_i), .ext_pin_i(ext_pin_i), .ext_rise_i(ext_rise_i),
    .port_b_i(port_b_i), .tbt_irq_i(tbt_irq_i), .tbt_slow_src_i(tbt_slow_src_i),
    .pwm_irq_i(pwm_irq_i), .pwm_slow_src_i(pwm_slow_src_i), .mode_o(mode_o),
    .fast_osc_en_o(fast_osc_en_o), .slow_osc_en_o(slow_osc_en_o),
    .cpu_fast_sel_o(cpu_fast_sel_o), .cpu_slow_sel_o(cpu_slow_sel_o),
    .cpu_tick_o(cpu_tick_o), .wdt_en_o(wdt_en_o), .wake_o(wake_o), .ext_irq_o(ext_irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic request(input logic [1:0] m);
    req_valid_i = 1'b1;
    req_mode_i  = m;
    step();
    req_valid_i = 1'b0;
  endtask

  // expected gates per mode code: {fast osc, slow osc, fast sel, slow sel}
  function automatic logic [3:0] exp_gates(input int m);
    case (m)
      0: return 4'b1110;
      1: return 4'b0101;
      2: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check_table(input int m);
    logic [3:0] g;
    g = {fast_osc_en_o, slow_osc_en_o, cpu_fast_sel_o, cpu_slow_sel_o};
    chk_eq("R2 mode code", mode_o, m);
    chk_eq("R2 clock gates", g, exp_gates(m));
    chk_eq("R4 watchdog enable", wdt_en_o, (m < 2) ? 1 : 0);
  endtask

  // leave idle/stop through a source valid in the current mode
  task automatic exit_low();
    if (mode_o == 2'd3) begin
      port_b_i = 8'hFE; step(); port_b_i = 8'hFF;
    end else begin
      tbt_slow_src_i = 1'b1; tbt_irq_i = 1'b1; step(); tbt_irq_i = 1'b0; tbt_slow_src_i = 1'b0;
    end
    settle(6);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      finish_run();
    end
  end

  initial begin
    int ticks;
    int pulses;
    settle(3);
    rst_ni = 1'b1;
    // R1 reset state
    chk_eq("R1 mode after reset", mode_o, 0);
    chk_eq("R1 gates after reset", {fast_osc_en_o, slow_osc_en_o, cpu_fast_sel_o, cpu_slow_sel_o}, 4'b1110);
    chk_eq("R1 watchdog after reset", wdt_en_o, 1);
    chk_eq("R1 wake after reset", wake_o, 0);
    settle(2);

    // R12 divider sweep in both run modes
    for (int rm = 0; rm < 2; rm++) begin
      if (rm == 1) begin request(2'd1); settle(GAP + 2); end
      check_table(rm);
      for (int d = 0; d < 4; d++) begin
        div_sel_i = d[1:0];
        ticks = 0;
        for (int c = 0; c < 32; c++) begin step(); ticks += cpu_tick_o; end
        chk_eq("R12 tick count", ticks, 32 >> d);
      end
    end
    div_sel_i = 2'd0;

    // R3 slow -> fast switch gap (now in slow run)
    request(2'd0);
    for (int c = 0; c < GAP; c++) begin
      chk_eq("R3 selects low in gap", {cpu_fast_sel_o, cpu_slow_sel_o}, 0);
      chk_eq("R3 oscillators on in gap", {fast_osc_en_o, slow_osc_en_o}, 3);
      chk_eq("R4 watchdog on in gap", wdt_en_o, 1);
      step();
    end
    chk_eq("R3 fast select after gap", {cpu_fast_sel_o, cpu_slow_sel_o}, 2);
    // R3 fast -> slow switch gap
    request(2'd1);
    for (int c = 0; c < GAP; c++) begin
      chk_eq("R3 selects low in gap", {cpu_fast_sel_o, cpu_slow_sel_o}, 0);
      step();
    end
    chk_eq("R3 slow select after gap", {cpu_fast_sel_o, cpu_slow_sel_o}, 1);

    // R10 return to slow run, R2 idle/stop tables, R12 no ticks
    for (int lp = 2; lp < 4; lp++) begin
      request(lp[1:0]);
      check_table(lp);
      ticks = 0;
      for (int c = 0; c < 8; c++) begin ticks += cpu_tick_o; step(); end
      chk_eq("R12 no tick in low power", ticks, 0);
      // R13 requests ignored in low power
      request(2'd0);
      settle(3);
      chk_eq("R13 request ignored in low power", mode_o, lp);
      exit_low();
      chk_eq("R10 return to slow run", mode_o, 1);
    end
    request(2'd0);
    settle(GAP + 2);
    check_table(0);

    // R13 request during switch ignored
    request(2'd1);
    request(2'd2);
    step();
    chk_eq("R13 request ignored while switching", mode_o, 1);
    chk_eq("R13 slow select after switch", cpu_slow_sel_o, 1);
    settle(4);
    chk_eq("R13 still slow run", mode_o, 1);
    request(2'd0);
    settle(GAP + 2);

    // R5 R6 R10 R11 external pin sweep, selected edge
    for (int i = 0; i < 3; i++)
      for (int pol = 0; pol < 2; pol++)
        for (int lp = 2; lp < 4; lp++) begin
          ext_rise_i = 3'b111; ext_rise_i[i] = pol[0];
          ext_pin_i = 3'b000; ext_pin_i[i] = ~pol[0];
          settle(6);
          request(lp[1:0]);
          ext_pin_i[i] = pol[0];
          step();
          if (lp == 3) begin
            chk_eq("R11 stop raw wake next cycle", mode_o, 0);
            chk_eq("R10 wake pulse", wake_o, 1);
            chk_eq("R11 sync irq not yet seen", ext_irq_o[i], 0);
          end else begin
            chk_eq("R6 idle waits for sync", mode_o, 2);
            step();
            chk_eq("R5 edge irq pulse", ext_irq_o[i], 1);
            chk_eq("R6 still idle at irq", mode_o, 2);
            step();
            chk_eq("R6 idle wake by edge", mode_o, 0);
            chk_eq("R10 wake pulse", wake_o, 1);
            chk_eq("R5 irq single cycle", ext_irq_o[i], 0);
            step();
            chk_eq("R10 wake pulse one cycle", wake_o, 0);
          end
          ext_rise_i = 3'b111; ext_pin_i = 3'b000;
          settle(6);
        end

    // R5 R6 opposite edge does nothing
    for (int i = 0; i < 3; i++)
      for (int pol = 0; pol < 2; pol++)
        for (int lp = 2; lp < 4; lp++) begin
          ext_rise_i = 3'b111; ext_rise_i[i] = pol[0];
          ext_pin_i = 3'b000; ext_pin_i[i] = pol[0];
          settle(6);
          request(lp[1:0]);
          ext_pin_i[i] = ~pol[0];
          pulses = 0;
          for (int c = 0; c < 6; c++) begin step(); pulses += ext_irq_o[i]; end
          chk_eq("R5 opposite edge no irq", pulses, 0);
          chk_eq("R6 opposite edge no wake", mode_o, lp);
          exit_low();
          ext_rise_i = 3'b111; ext_pin_i = 3'b000;
          settle(6);
        end

    // R7 port B low-level sweep
    for (int b = 0; b < 8; b++)
      for (int lp = 2; lp < 4; lp++) begin
        request(lp[1:0]);
        port_b_i = 8'hFF; port_b_i[b] = 1'b0;
        if (lp == 2) begin
          settle(2);
          chk_eq("R7 idle waits for sync", mode_o, 2);
        end
        step();
        chk_eq("R7 port low wake", mode_o, 0);
        chk_eq("R10 wake pulse", wake_o, 1);
        port_b_i = 8'hFF;
        settle(6);
      end

    // R8 R9 timer and PWM qualification
    for (int src = 0; src < 2; src++)
      for (int sl = 0; sl < 2; sl++)
        for (int lp = 2; lp < 4; lp++) begin
          request(lp[1:0]);
          if (src == 0) begin tbt_slow_src_i = sl[0]; tbt_irq_i = 1'b1; end
          else begin pwm_slow_src_i = sl[0]; pwm_irq_i = 1'b1; end
          step();
          tbt_irq_i = 1'b0; pwm_irq_i = 1'b0;
          tbt_slow_src_i = 1'b0; pwm_slow_src_i = 1'b0;
          if (lp == 2) chk_eq("R8 idle timer/pwm wake by source", mode_o, (sl == 1) ? 0 : 2);
          else         chk_eq("R9 stop ignores timer/pwm", mode_o, 3);
          if (mode_o != 2'd0) exit_low();
          else settle(4);
        end

    done = 1'b1;
    finish_run();
  end
endmodule